// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the external memory bus timing for a small 8-bit controller core. Time is counted in oscillator periods: the block advances one step for each clock on which the oscillator enable is high, and twelve such steps form one machine cycle. In every machine cycle it drives the address latch strobe, the code read strobe, the data read and data write strobes, a port that carries the low address byte and the write data, and a port that carries the high address byte.

The core presents its request for the coming machine cycle on the last oscillator period of the current one: either an ordinary code fetch (two bytes, at the given pointer and the pointer plus one) or an external data transfer (read or write, with a 16-bit or an 8-bit pointer), together with the external-execution strap, a flag that a code-table read is under way, and the latch-strobe disable bit. The latch strobe runs freely at two pulses per machine cycle. A data transfer cycle gives up its second latch pulse and both code read pulses in exchange for one six-period read or write strobe. The disable bit silences the latch strobe only in cycles where no external access can need it.

Top module: `ext_bus_seq`

## Requirements
- R1: A machine cycle is 12 enabled oscillator periods; no output changes on a clock where `osc_en` is low. During and right after reset `ale`=0, `ale_weak`=0, `psen_n`=`rd_n`=`wr_n`=1, `p0_oe`=0 and `p2_out`=0.
- R2: In a fetch cycle with the latch strobe enabled, `ale` is high in phases 0-1 and 6-7 (phase 0 is the first period of the cycle), giving two pulses of exactly 2 periods each.
- R3: In a fetch cycle with `ea_ext`=1, `psen_n` is low in phases 3-5 and 9-11 (two pulses of 3 periods); with `ea_ext`=0 it stays high.
- R4: In a data cycle, `ale` pulses only in phases 0-1 and `psen_n` stays high for the whole cycle.
- R5: In a data cycle `rd_n` (read, `xd_write`=0) or `wr_n` (write, `xd_write`=1) is low in phases 5-10, exactly 6 periods; the two are never low together.
- R6: The read or write strobe falls 3 periods after `ale` falls, and `ale` rises 1 period after the strobe rises when the next cycle has its latch strobe enabled.
- R7: When `ale_off`=1 in a fetch cycle with `ea_ext`=0 and `movc_busy`=0, `ale` stays low for the whole cycle and `ale_weak`=1.
- R8: `ale_off`=1 has no effect (full pulses, `ale_weak`=0) in data cycles, in cycles with `ea_ext`=1 and in cycles with `movc_busy`=1.
- R9: Port 0 drives a low address byte (`p0_oe`=1) in phases 0-2 and, in external fetch cycles, 6-8: the fetch pointer low byte in the first half, the pointer plus one low byte in the second, and the data pointer low byte in a data cycle; otherwise `p0_oe`=0.
- R10: In a write cycle `p0_out` carries `xd_wdata` with `p0_oe`=1 during phases 5-10, covering every period in which `wr_n` is low.
- R11: `p2_out` is the data pointer high byte in a data cycle with `xd_wide`=1, `p2_latch` in a data cycle with `xd_wide`=0, the high byte of the current fetch pointer (pointer plus one from phase 6) in an external fetch cycle, and `p2_latch` in an internal fetch cycle.
- R12: All request inputs are sampled only on the enabled clock that ends phase 11; their values at any other time have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_en | input | 1 | One oscillator period elapses on each clock with this high |
| ea_ext | input | 1 | Code executes from external memory in the next cycle |
| fetch_addr | input | 16 | Code pointer for the next fetch cycle |
| movc_busy | input | 1 | A code-table read is under way in the next cycle |
| xd_req | input | 1 | Next cycle is an external data transfer |
| xd_write | input | 1 | Data transfer is a write (1) or read (0) |
| xd_wide | input | 1 | Data transfer uses a 16-bit pointer (1) or an 8-bit one (0) |
| xd_addr | input | 16 | Data pointer |
| xd_wdata | input | 8 | Write data |
| p2_latch | input | 8 | Current contents of the port 2 output register |
| ale_off | input | 1 | Latch strobe disable bit |
| ale | output | 1 | Address latch strobe, active high |
| ale_weak | output | 1 | Latch strobe silenced; pad holds it weakly high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Port 0 address/data byte |
| p0_oe | output | 1 | Port 0 drive enable |
| p2_out | output | 8 | Port 2 byte |

## Verification
The bench aims at the boundary between a data cycle and its neighbours, where a design that counted the strobe window from the wrong ALE edge would open the read strobe early or let the next ALE overlap its tail, and at the disable bit, where a design that gated it without the external-execution, table-read or data-cycle exceptions would drop address latches that external memory needs. It also wraps the fetch pointer at its top value, where a second-half address formed with a carry into a wider field would put a wrong byte on port 2, and inserts gaps in the oscillator enable, which a design that advanced on every clock would turn into short strobes. Request inputs are scrambled outside the sampling period, so a design that looked at them live would show it on the ports.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  // timing of one machine cycle, in oscillator periods
  localparam int MC_LEN   = 12;
  localparam int HALF     = MC_LEN / 2;
  localparam int ALE_LEN  = 2;
  localparam int ADDR_LEN = ALE_LEN + 1;   // address held one period past ALE fall
  localparam int PSEN_OFS = ALE_LEN + 1;
  localparam int PSEN_LEN = 3;
  localparam int STB_OFS  = ALE_LEN + 3;   // RD/WR fall 3 periods after ALE fall
  localparam int STB_LEN  = 6;
  localparam int PH_W     = $clog2(MC_LEN);

  typedef logic [PH_W-1:0] phase_t;

  typedef struct packed {
    logic data;
    logic wr;
    logic wide;
    logic ext;
    logic movc;
    logic ale_off;
  } cyc_flags_t;

  // true when phase p lies in [start, start+len)
  function automatic logic in_win(phase_t p, int start, int len);
    return (int'(p) >= start) && (int'(p) < start + len);
  endfunction

  // second half of a fetch cycle reads the following code byte
  function automatic logic second_half(phase_t p);
    return int'(p) >= HALF;
  endfunction
endpackage

// File: rtl/ebs_phase_gen.sv
module ebs_phase_gen
  import ebs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   osc_en,
  output phase_t ph,
  output logic   mc_wrap
);
  localparam phase_t LAST = phase_t'(MC_LEN - 1);

  assign mc_wrap = osc_en && (ph == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ph <= LAST;
    else if (mc_wrap) ph <= '0;
    else if (osc_en)  ph <= ph + phase_t'(1);
  end
endmodule

// File: rtl/ebs_cycle_reg.sv
module ebs_cycle_reg
  import ebs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  cyc_flags_t    flg_in,
  input  logic [AW-1:0] faddr_in,
  input  logic [AW-1:0] xaddr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] p2_in,
  output cyc_flags_t    flg,
  output logic [AW-1:0] faddr,
  output logic [AW-1:0] xaddr,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] p2reg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg   <= '0;
      faddr <= '0;
      xaddr <= '0;
      wdata <= '0;
      p2reg <= '0;
    end else if (take) begin
      flg   <= flg_in;
      faddr <= faddr_in;
      xaddr <= xaddr_in;
      wdata <= wdata_in;
      p2reg <= p2_in;
    end
  end
endmodule

// File: rtl/ebs_strobe_dec.sv
module ebs_strobe_dec
  import ebs_pkg::*;
(
  input  phase_t     ph,
  input  cyc_flags_t flg,
  output logic       ale,
  output logic       ale_weak,
  output logic       psen_n,
  output logic       rd_n,
  output logic       wr_n,
  output logic       ale_slot,
  output logic       ale_gate,
  output logic       stb_win
);
  logic psen_act;

  // a data cycle keeps only the first latch slot
  assign ale_slot = in_win(ph, 0, ALE_LEN) ||
                    (!flg.data && in_win(ph, HALF, ALE_LEN));
  // the disable bit only bites when no external access is possible
  assign ale_gate = !flg.ale_off || flg.data || flg.ext || flg.movc;
  assign ale      = ale_slot && ale_gate;
  assign ale_weak = !ale_gate;

  assign psen_act = flg.ext && !flg.data &&
                    (in_win(ph, PSEN_OFS, PSEN_LEN) ||
                     in_win(ph, HALF + PSEN_OFS, PSEN_LEN));
  assign psen_n   = !psen_act;

  assign stb_win  = flg.data && in_win(ph, STB_OFS, STB_LEN);
  assign rd_n     = !(stb_win && !flg.wr);
  assign wr_n     = !(stb_win && flg.wr);
endmodule

// File: rtl/ebs_port_mux.sv
module ebs_port_mux
  import ebs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  phase_t        ph,
  input  cyc_flags_t    flg,
  input  logic [AW-1:0] faddr,
  input  logic [AW-1:0] xaddr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] p2reg,
  output logic [DW-1:0] p0_out,
  output logic          p0_oe,
  output logic [DW-1:0] p2_out
);
  logic [AW-1:0] code_ptr;
  logic          fetch_addr_win;

  assign code_ptr       = second_half(ph) ? faddr + AW'(1) : faddr;
  assign fetch_addr_win = in_win(ph, 0, ADDR_LEN) || in_win(ph, HALF, ADDR_LEN);

  always_comb begin
    p0_oe  = 1'b0;
    p0_out = '0;
    if (flg.data) begin
      if (in_win(ph, 0, ADDR_LEN)) begin
        p0_oe  = 1'b1;
        p0_out = xaddr[DW-1:0];
      end else if (flg.wr && in_win(ph, STB_OFS, STB_LEN)) begin
        p0_oe  = 1'b1;
        p0_out = wdata;
      end
    end else if (flg.ext && fetch_addr_win) begin
      p0_oe  = 1'b1;
      p0_out = code_ptr[DW-1:0];
    end
  end

  always_comb begin
    if (flg.data)     p2_out = flg.wide ? xaddr[AW-1:DW] : p2reg;
    else if (flg.ext) p2_out = code_ptr[AW-1:DW];
    else              p2_out = p2reg;
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_en,
  input  logic          ea_ext,
  input  logic [AW-1:0] fetch_addr,
  input  logic          movc_busy,
  input  logic          xd_req,
  input  logic          xd_write,
  input  logic          xd_wide,
  input  logic [AW-1:0] xd_addr,
  input  logic [DW-1:0] xd_wdata,
  input  logic [DW-1:0] p2_latch,
  input  logic          ale_off,
  output logic          ale,
  output logic          ale_weak,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] p0_out,
  output logic          p0_oe,
  output logic [DW-1:0] p2_out
);
  phase_t        ph_w;
  logic          mc_wrap;
  cyc_flags_t    req_flg, cur_flg;
  logic [AW-1:0] cur_faddr, cur_xaddr;
  logic [DW-1:0] cur_wdata, cur_p2;
  logic          ale_slot, ale_gate, stb_win;

  always_comb begin
    req_flg.data    = xd_req;
    req_flg.wr      = xd_write;
    req_flg.wide    = xd_wide;
    req_flg.ext     = ea_ext;
    req_flg.movc    = movc_busy;
    req_flg.ale_off = ale_off;
  end

  ebs_phase_gen u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_en  (osc_en),
    .ph      (ph_w),
    .mc_wrap (mc_wrap)
  );

  ebs_cycle_reg #(.DW(DW), .AW(AW)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (mc_wrap),
    .flg_in   (req_flg),
    .faddr_in (fetch_addr),
    .xaddr_in (xd_addr),
    .wdata_in (xd_wdata),
    .p2_in    (p2_latch),
    .flg      (cur_flg),
    .faddr    (cur_faddr),
    .xaddr    (cur_xaddr),
    .wdata    (cur_wdata),
    .p2reg    (cur_p2)
  );

  ebs_strobe_dec u_dec (
    .ph       (ph_w),
    .flg      (cur_flg),
    .ale      (ale),
    .ale_weak (ale_weak),
    .psen_n   (psen_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ale_slot (ale_slot),
    .ale_gate (ale_gate),
    .stb_win  (stb_win)
  );

  ebs_port_mux #(.DW(DW), .AW(AW)) u_mux (
    .ph     (ph_w),
    .flg    (cur_flg),
    .faddr  (cur_faddr),
    .xaddr  (cur_xaddr),
    .wdata  (cur_wdata),
    .p2reg  (cur_p2),
    .p0_out (p0_out),
    .p0_oe  (p0_oe),
    .p2_out (p2_out)
  );
endmodule

// File: rtl/ebs_checker.sv
module ebs_checker
  import ebs_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic ale,
  input logic ale_weak,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic p0_oe
);
  localparam logic [7:0] ALE_RUN  = 8'(ALE_LEN);
  localparam logic [7:0] PSEN_RUN = 8'(PSEN_LEN);
  localparam logic [7:0] STB_RUN  = 8'(STB_LEN);

  logic [7:0] ale_run, psen_run, stb_run;
  logic       stb_on;

  assign stb_on = !rd_n || !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_run  <= '0;
      psen_run <= '0;
      stb_run  <= '0;
    end else if (osc_en) begin
      ale_run  <= ale     ? ale_run + 8'd1  : 8'd0;
      psen_run <= !psen_n ? psen_run + 8'd1 : 8'd0;
      stb_run  <= stb_on  ? stb_run + 8'd1  : 8'd0;
    end
  end

  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && !ale && ale_run != 8'd0) |-> ale_run == ALE_RUN);        // R2
  AST_PSEN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && psen_n && psen_run != 8'd0) |-> psen_run == PSEN_RUN);   // R3
  AST_STB_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && !stb_on && stb_run != 8'd0) |-> stb_run == STB_RUN);     // R5
  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));                                                 // R5
  AST_NO_PSEN_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    stb_on |-> psen_n);                                                 // R4
  AST_ALE_PSEN_APART: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> psen_n);                                                    // R2
  AST_WDATA_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> p0_oe);                                                   // R10
  AST_WEAK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ale_weak |-> !ale);                                                 // R7
  AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> $stable({ale, psen_n, rd_n, wr_n, p0_oe}));             // R1
endmodule

bind ext_bus_seq ebs_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .osc_en   (osc_en),
  .ale      (ale),
  .ale_weak (ale_weak),
  .psen_n   (psen_n),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .p0_oe    (p0_oe)
);

// File: tb/ext_bus_seq_test.sv
module ext_bus_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, osc_en, ea_ext, movc_busy, xd_req, xd_write, xd_wide, ale_off;
  logic [15:0] fetch_addr, xd_addr;
  logic [7:0]  xd_wdata, p2_latch;
  logic        ale, ale_weak, psen_n, rd_n, wr_n, p0_oe;
  logic [7:0]  p0_out, p2_out;

  ext_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .ea_ext(ea_ext),
    .fetch_addr(fetch_addr), .movc_busy(movc_busy), .xd_req(xd_req),
    .xd_write(xd_write), .xd_wide(xd_wide), .xd_addr(xd_addr),
    .xd_wdata(xd_wdata), .p2_latch(p2_latch), .ale_off(ale_off),
    .ale(ale), .ale_weak(ale_weak), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out)
  );

  int n_chk = 0, n_fail = 0;

  // bench model of the cycle in progress, and the request to load next
  bit m_d, m_w, m_wide, m_x, m_movc, m_off;
  logic [15:0] m_fa, m_xa;
  logic [7:0]  m_wd, m_p2;
  int mph;
  bit q_d, q_w, q_wide, q_x, q_movc, q_off;
  logic [15:0] q_fa, q_xa;
  logic [7:0]  q_wd, q_p2;

  // observation history
  bit pv_ale, pv_psen_n, pv_rd_n, pv_wr_n, pv_oe;
  logic [7:0] pv_p2;
  int ale_len, psen_len, stb_len, since_ale, since_stb;
  bit stb_flag;
  int cyc_ale, cyc_psen, cyc_stb;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit x_gate();
    return m_d || m_x || m_movc || !m_off;
  endfunction

  function automatic bit x_ale(int p);
    bit first_slot = (p == 0) || (p == 1);
    bit second_slot = !m_d && (p == 6 || p == 7);
    return (first_slot || second_slot) && x_gate();
  endfunction

  function automatic bit x_psen_n(int p);
    if (!m_x || m_d) return 1'b1;
    return !((p >= 3 && p <= 5) || p >= 9);
  endfunction

  function automatic bit x_stb(int p);
    return m_d && p >= 5 && p <= 10;
  endfunction

  function automatic logic [15:0] x_code(int p);
    return (p >= 6) ? m_fa + 16'd1 : m_fa;
  endfunction

  function automatic bit x_oe(int p);
    if (m_d) return (p <= 2) || (m_w && p >= 5 && p <= 10);
    if (m_x) return (p <= 2) || (p >= 6 && p <= 8);
    return 1'b0;
  endfunction

  function automatic logic [7:0] x_p0(int p);
    if (m_d) return (p <= 2) ? m_xa[7:0] : m_wd;
    return x_code(p)[7:0];
  endfunction

  function automatic logic [7:0] x_p2(int p);
    if (m_d) return m_wide ? m_xa[15:8] : m_p2;
    if (m_x) return x_code(p)[15:8];
    return m_p2;
  endfunction

  task automatic drive_junk();
    fetch_addr = 16'($urandom); xd_addr = 16'($urandom);
    xd_wdata = 8'($urandom); p2_latch = 8'($urandom);
    ea_ext = 1'($urandom); movc_busy = 1'($urandom); xd_req = 1'($urandom);
    xd_write = 1'($urandom); xd_wide = 1'($urandom); ale_off = 1'($urandom);
  endtask

  task automatic drive_pending();
    fetch_addr = q_fa; xd_addr = q_xa; xd_wdata = q_wd; p2_latch = q_p2;
    ea_ext = q_x; movc_busy = q_movc; xd_req = q_d; xd_write = q_w;
    xd_wide = q_wide; ale_off = q_off;
  endtask

  task automatic snapshot();
    pv_ale = ale; pv_psen_n = psen_n; pv_rd_n = rd_n; pv_wr_n = wr_n;
    pv_oe = p0_oe; pv_p2 = p2_out;
  endtask

  task automatic step(bit en);
    bit wrap, stb_now, stb_was;
    string atag;
    wrap = en && (mph == 11);
    @(negedge clk);
    osc_en = en;
    if (wrap) drive_pending(); else drive_junk();   // R12: junk between samples
    @(posedge clk);
    #1;
    if (!en) begin
      chk(ale == pv_ale && psen_n == pv_psen_n && rd_n == pv_rd_n && wr_n == pv_wr_n
          && p0_oe == pv_oe && p2_out == pv_p2, "R1", "outputs moved without osc_en",
          {ale, psen_n, rd_n, wr_n, p0_oe}, {pv_ale, pv_psen_n, pv_rd_n, pv_wr_n, pv_oe});
      return;
    end
    if (wrap) begin
      m_d = q_d; m_w = q_w; m_wide = q_wide; m_x = q_x; m_movc = q_movc; m_off = q_off;
      m_fa = q_fa; m_xa = q_xa; m_wd = q_wd; m_p2 = q_p2;
      mph = 0;
      cyc_ale = 0; cyc_psen = 0; cyc_stb = 0;
    end else mph++;

    if (m_off) atag = x_gate() ? "R8" : "R7";
    else       atag = m_d ? "R4" : "R2";
    chk(ale == x_ale(mph), atag, $sformatf("ale at phase %0d", mph), ale, x_ale(mph));
    chk(ale_weak == !x_gate(), atag, "ale_weak", ale_weak, !x_gate());
    chk(psen_n == x_psen_n(mph), m_d ? "R4" : "R3", $sformatf("psen_n at phase %0d", mph),
        psen_n, x_psen_n(mph));
    chk(rd_n == !(x_stb(mph) && !m_w), "R5", $sformatf("rd_n at phase %0d", mph),
        rd_n, !(x_stb(mph) && !m_w));
    chk(wr_n == !(x_stb(mph) && m_w), "R5", $sformatf("wr_n at phase %0d", mph),
        wr_n, !(x_stb(mph) && m_w));
    chk(p0_oe == x_oe(mph), (mph <= 2 || mph >= 6) ? "R9" : "R10",
        $sformatf("p0_oe at phase %0d", mph), p0_oe, x_oe(mph));
    if (x_oe(mph))
      chk(p0_out == x_p0(mph), (m_d && mph >= 5) ? "R10" : "R9/R12",
          $sformatf("p0_out at phase %0d", mph), p0_out, x_p0(mph));
    chk(p2_out == x_p2(mph), "R11/R12", $sformatf("p2_out at phase %0d", mph),
        p2_out, x_p2(mph));

    // pulse widths and spacing, in enabled periods
    since_ale++; since_stb++;
    stb_now = !rd_n || !wr_n;
    stb_was = !pv_rd_n || !pv_wr_n;
    if (ale && !pv_ale) begin
      cyc_ale++; ale_len = 1;
      if (stb_flag) chk(since_stb == 1, "R6", "ALE rise after strobe rise", since_stb, 1);
    end else if (ale) ale_len++;
    if (!ale && pv_ale) begin
      chk(ale_len == 2, "R2", "ALE high width", ale_len, 2);
      since_ale = 0;
    end
    if (!psen_n && pv_psen_n) begin cyc_psen++; psen_len = 1; end
    else if (!psen_n) psen_len++;
    if (psen_n && !pv_psen_n) chk(psen_len == 3, "R3", "PSEN low width", psen_len, 3);
    if (stb_now && !stb_was) begin
      cyc_stb++; stb_len = 1;
      chk(since_ale == 3, "R6", "strobe fall after ALE fall", since_ale, 3);
    end else if (stb_now) stb_len++;
    if (!stb_now && stb_was) begin
      chk(stb_len == 6, "R5", "RD/WR low width", stb_len, 6);
      since_stb = 0; stb_flag = 1'b1;
    end
    if (since_stb >= 1) stb_flag = 1'b0;
    snapshot();
  endtask

  task automatic run_cycle(bit d, bit w, bit wide, bit x, bit movc, bit off,
                           logic [15:0] fa, logic [15:0] xa, logic [7:0] wd,
                           logic [7:0] p2, bit gaps);
    int exp_ale;
    q_d = d; q_w = w; q_wide = wide; q_x = x; q_movc = movc; q_off = off;
    q_fa = fa; q_xa = xa; q_wd = wd; q_p2 = p2;
    for (int i = 0; i < 12; i++) begin
      if (gaps && ($urandom % 4 == 0)) step(1'b0);
      step(1'b1);
    end
    exp_ale = x_gate() ? (m_d ? 1 : 2) : 0;
    chk(cyc_ale == exp_ale, m_d ? "R4" : (m_off ? "R7" : "R2"), "ALE pulses per cycle",
        cyc_ale, exp_ale);
    chk(cyc_psen == ((m_x && !m_d) ? 2 : 0), m_d ? "R4" : "R3", "PSEN pulses per cycle",
        cyc_psen, (m_x && !m_d) ? 2 : 0);
    chk(cyc_stb == (m_d ? 1 : 0), "R5", "RD/WR pulses per cycle", cyc_stb, m_d ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C51));
    rst_n = 1'b0; osc_en = 1'b0;
    drive_junk();
    repeat (4) begin
      @(negedge clk); osc_en = 1'($urandom);
    end
    #1;
    // R1: reset state
    chk(ale == 1'b0 && ale_weak == 1'b0, "R1", "ale/ale_weak in reset", {ale, ale_weak}, 0);
    chk(psen_n && rd_n && wr_n, "R1", "read/write strobes in reset", {psen_n, rd_n, wr_n}, 7);
    chk(p0_oe == 1'b0 && p2_out == 8'h00, "R1", "ports in reset", {p0_oe, p2_out}, 0);
    @(negedge clk); rst_n = 1'b1; osc_en = 1'b0;
    @(posedge clk); #1;
    chk(ale == 1'b0 && psen_n && rd_n && wr_n && !p0_oe, "R1", "idle after reset release",
        {ale, psen_n, rd_n, wr_n, p0_oe}, 5'b01110);
    mph = 11; m_d = 0; m_w = 0; m_wide = 0; m_x = 0; m_movc = 0; m_off = 0;
    m_fa = '0; m_xa = '0; m_wd = '0; m_p2 = '0;
    ale_len = 0; psen_len = 0; stb_len = 0; since_ale = 0; since_stb = 9; stb_flag = 0;
    snapshot();

    // directed: fetch internal, fetch external, data read narrow, write wide
    run_cycle(0, 0, 0, 0, 0, 0, 16'h1234, 16'h0, 8'h0, 8'hA5, 0);          // R2
    run_cycle(0, 0, 0, 1, 0, 0, 16'h2040, 16'h0, 8'h0, 8'h5A, 0);          // R3 R9 R11
    run_cycle(1, 0, 0, 1, 0, 0, 16'h2042, 16'hBE37, 8'h0, 8'hC3, 0);       // R4 R5 R11 narrow
    run_cycle(1, 1, 1, 0, 0, 0, 16'h0, 16'h7F81, 8'h96, 8'h11, 0);         // R5 R10 R11 wide
    run_cycle(1, 1, 0, 1, 0, 0, 16'h0, 16'h0042, 8'h3C, 8'h22, 0);         // R6 back-to-back
    run_cycle(0, 0, 0, 1, 0, 0, 16'hFFFF, 16'h0, 8'h0, 8'h00, 0);          // R9 R11 pointer wrap
    // disable bit
    run_cycle(0, 0, 0, 0, 0, 1, 16'h0100, 16'h0, 8'h0, 8'h44, 0);          // R7
    run_cycle(0, 0, 0, 0, 1, 1, 16'h0100, 16'h0, 8'h0, 8'h44, 0);          // R8 table read
    run_cycle(0, 0, 0, 1, 0, 1, 16'h0300, 16'h0, 8'h0, 8'h44, 0);          // R8 external code
    run_cycle(1, 0, 1, 0, 0, 1, 16'h0, 16'hCAFE, 8'h0, 8'h44, 0);          // R8 data cycle
    run_cycle(0, 0, 0, 0, 0, 1, 16'h0100, 16'h0, 8'h0, 8'h44, 1);          // R7 with gaps R1
    run_cycle(1, 0, 0, 0, 0, 0, 16'h0, 16'h00FF, 8'h0, 8'h77, 1);          // R6 after silenced

    // random mix with oscillator enable gaps
    for (int n = 0; n < 300; n++) begin
      bit d = ($urandom % 3 == 0);
      run_cycle(d, 1'($urandom), 1'($urandom), 1'($urandom), d ? 1'b0 : 1'($urandom),
                ($urandom % 3 == 0), 16'($urandom), 16'($urandom), 8'($urandom),
                8'($urandom), ($urandom % 2 == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule